// File: doc/BRIEF.md
# Power Domain Session Sleep Arbiter

This block decides which of a set of power domains are allowed to power down. It keeps a square matrix of one-bit entries, one row and one column per domain. An off-diagonal entry at row i, column k is set while domain i holds an open session towards domain k. A domain must hold such a session before it exchanges traffic with that peer. Each diagonal entry stores that domain's own wish to sleep. A domain is eligible to sleep only when three things hold: it has asked to sleep, it holds no session of its own, and no other domain holds a session towards it.

Domains reach the block through a single command port that takes one command per cycle. A command carries an operation code, a source domain and a destination domain. On the next cycle the block answers with a response that says whether the command was accepted. A fixed connection mask, set at elaboration, states which source and destination pairs may ever hold a session. Opening a session towards a sleeping domain cancels that domain's sleep request and sends it a one-cycle wake pulse. The registered can-sleep vector goes to the power subsystem, which switches the rails and gates the clocks.

Top module: `session_sleep_arbiter`

## Requirements
- R1: While reset is high and on the first cycle after it, `can_sleep`, `wake_req` and `rsp_valid` are all zero, and the matrix is empty.
- R2: A command sampled with `cmd_valid` high produces `rsp_valid` high on exactly the next cycle. A cycle with `cmd_valid` low produces `rsp_valid` low on the next cycle.
- R3: The operation codes are: 2'b00 opens a session from `cmd_src` to `cmd_dst`, 2'b01 closes it, 2'b10 sets the sleep request of `cmd_src`, and 2'b11 clears the sleep request of `cmd_src`. Set and clear are always accepted.
- R4: `can_sleep[i]` is 1 exactly when three conditions hold: domain i's sleep request is set, row i holds no off-diagonal 1, and column i holds no off-diagonal 1. It is registered, so it reflects a matrix change one cycle after the response to the command that made it.
- R5: An open or close whose source equals its destination is rejected (`rsp_accept`=0, `rsp_no_session`=0) and leaves the matrix unchanged.
- R6: An open on a pair whose mask bit `CONN_MASK[src*NUM_DOM+dst]` is 0 is rejected (`rsp_accept`=0, `rsp_no_session`=0) and leaves the matrix unchanged.
- R7: An open on an allowed pair with distinct IDs is accepted and sets entry (src,dst). This also holds when that entry is already set.
- R8: An accepted open clears the destination's sleep request. If `can_sleep[dst]` was 1 in the cycle the command was presented, `wake_req[dst]` alone is high for exactly the one cycle on which the response is valid. Otherwise `wake_req` stays zero.
- R9: A close with distinct IDs on a set entry is accepted and clears that entry. On a clear entry it returns `rsp_accept`=0 and `rsp_no_session`=1 and changes nothing.
- R10: While `cmd_valid` is low, the values on `cmd_op`, `cmd_src` and `cmd_dst` change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | Operation code (see R3) |
| cmd_src | input | ID_W | Source domain ID |
| cmd_dst | input | ID_W | Destination domain ID |
| rsp_valid | output | 1 | Response to the previous cycle's command |
| rsp_accept | output | 1 | Command was carried out |
| rsp_no_session | output | 1 | Close found no open session |
| can_sleep | output | NUM_DOM | Per-domain sleep eligibility |
| wake_req | output | NUM_DOM | One-cycle wake pulse per domain |

## Verification
The bench first raises every domain's sleep request. It then opens every ordered pair of the 8x8 ID space against an asymmetric connection mask. In this way, diagonal rejections, mask rejections, repeated opens and wake pulses are each exercised against a domain that is asleep and against one that is already awake. A full close sweep follows. Pairs that are open must be accepted and pairs that are not must report a missing session, which shows that rejected opens left no entry behind. Idle cycles that carry garbage command fields show that only `cmd_valid` starts a change. After every command, the response and the can-sleep vector are compared with a bench matrix model, so a fault in the row term and a fault in the column term give different mismatches.

// File: rtl/sas_pkg.sv
package sas_pkg;

  typedef enum logic [1:0] {
    OP_OPEN      = 2'b00,
    OP_CLOSE     = 2'b01,
    OP_SLEEP_SET = 2'b10,
    OP_SLEEP_CLR = 2'b11
  } sas_op_e;

  typedef struct packed {
    logic valid;
    logic accept;
    logic no_session;
  } sas_rsp_t;

endpackage

// File: rtl/sas_cmd_decode.sv
module sas_cmd_decode
  import sas_pkg::*;
#(
  parameter int NUM_DOM = 8,
  parameter int ID_W    = $clog2(NUM_DOM),
  parameter logic [NUM_DOM*NUM_DOM-1:0] CONN_MASK = '1
) (
  input  logic                            cmd_valid,
  input  logic [1:0]                      cmd_op,
  input  logic [ID_W-1:0]                 cmd_src,
  input  logic [ID_W-1:0]                 cmd_dst,
  input  logic [NUM_DOM-1:0][NUM_DOM-1:0] mat,
  input  logic [NUM_DOM-1:0]              asleep,
  output logic [NUM_DOM-1:0][NUM_DOM-1:0] set_m,
  output logic [NUM_DOM-1:0][NUM_DOM-1:0] clr_m,
  output sas_rsp_t                        rsp_d,
  output logic [NUM_DOM-1:0]              wake_d
);

  // Connection table reshaped to rows (source) by columns (destination).
  logic [NUM_DOM-1:0][NUM_DOM-1:0] allow;

  for (genvar s = 0; s < NUM_DOM; s++) begin : g_row
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_col
      assign allow[s][d] = CONN_MASK[s*NUM_DOM+d];
    end
  end

  logic same_id;
  assign same_id = (cmd_src == cmd_dst);

  always_comb begin
    set_m  = '0;
    clr_m  = '0;
    wake_d = '0;
    rsp_d  = '0;
    rsp_d.valid = cmd_valid;
    if (cmd_valid) begin
      unique case (sas_op_e'(cmd_op))
        OP_OPEN: begin
          if (!same_id && allow[cmd_src][cmd_dst]) begin
            rsp_d.accept             = 1'b1;
            set_m[cmd_src][cmd_dst]  = 1'b1;
            clr_m[cmd_dst][cmd_dst]  = 1'b1;
            wake_d[cmd_dst]          = asleep[cmd_dst];
          end
        end
        OP_CLOSE: begin
          if (!same_id) begin
            if (mat[cmd_src][cmd_dst]) begin
              rsp_d.accept            = 1'b1;
              clr_m[cmd_src][cmd_dst] = 1'b1;
            end else begin
              rsp_d.no_session = 1'b1;
            end
          end
        end
        OP_SLEEP_SET: begin
          rsp_d.accept            = 1'b1;
          set_m[cmd_src][cmd_src] = 1'b1;
        end
        OP_SLEEP_CLR: begin
          rsp_d.accept            = 1'b1;
          clr_m[cmd_src][cmd_src] = 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sas_session_matrix.sv
module sas_session_matrix #(
  parameter int NUM_DOM = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_DOM-1:0][NUM_DOM-1:0] set_m,
  input  logic [NUM_DOM-1:0][NUM_DOM-1:0] clr_m,
  output logic [NUM_DOM-1:0][NUM_DOM-1:0] mat_q
);

  // One flop per cell: every row and column is read in parallel, so the
  // storage stays in fabric registers.
  for (genvar r = 0; r < NUM_DOM; r++) begin : g_r
    for (genvar c = 0; c < NUM_DOM; c++) begin : g_c
      always_ff @(posedge clk) begin
        if (rst) begin
          mat_q[r][c] <= 1'b0;
        end else if (set_m[r][c]) begin
          mat_q[r][c] <= 1'b1;
        end else if (clr_m[r][c]) begin
          mat_q[r][c] <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/sas_sleep_eval.sv
module sas_sleep_eval #(
  parameter int NUM_DOM = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_DOM-1:0][NUM_DOM-1:0] mat,
  output logic [NUM_DOM-1:0]              can_sleep_q
);

  for (genvar i = 0; i < NUM_DOM; i++) begin : g_dom
    logic busy;

    // Own sessions (row i) or sessions aimed at i (column i), diagonal excluded.
    always_comb begin
      busy = 1'b0;
      for (int k = 0; k < NUM_DOM; k++) begin
        if (k != i) begin
          busy = busy | mat[i][k] | mat[k][i];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        can_sleep_q[i] <= 1'b0;
      end else begin
        can_sleep_q[i] <= mat[i][i] & ~busy;
      end
    end
  end

endmodule

// File: rtl/session_sleep_arbiter.sv
module session_sleep_arbiter
  import sas_pkg::*;
#(
  parameter int NUM_DOM = 8,
  parameter int ID_W    = $clog2(NUM_DOM),
  parameter logic [NUM_DOM*NUM_DOM-1:0] CONN_MASK = '1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_op,
  input  logic [ID_W-1:0]    cmd_src,
  input  logic [ID_W-1:0]    cmd_dst,
  output logic               rsp_valid,
  output logic               rsp_accept,
  output logic               rsp_no_session,
  output logic [NUM_DOM-1:0] can_sleep,
  output logic [NUM_DOM-1:0] wake_req
);

  logic [NUM_DOM-1:0][NUM_DOM-1:0] mat_q;
  logic [NUM_DOM-1:0][NUM_DOM-1:0] set_m;
  logic [NUM_DOM-1:0][NUM_DOM-1:0] clr_m;
  sas_rsp_t                        rsp_d;
  sas_rsp_t                        rsp_q;
  logic [NUM_DOM-1:0]              wake_d;
  logic [NUM_DOM-1:0]              wake_q;
  logic [NUM_DOM-1:0]              cs_q;

  sas_cmd_decode #(
    .NUM_DOM  (NUM_DOM),
    .ID_W     (ID_W),
    .CONN_MASK(CONN_MASK)
  ) u_decode (
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .cmd_src  (cmd_src),
    .cmd_dst  (cmd_dst),
    .mat      (mat_q),
    .asleep   (cs_q),
    .set_m    (set_m),
    .clr_m    (clr_m),
    .rsp_d    (rsp_d),
    .wake_d   (wake_d)
  );

  sas_session_matrix #(
    .NUM_DOM(NUM_DOM)
  ) u_matrix (
    .clk  (clk),
    .rst  (rst),
    .set_m(set_m),
    .clr_m(clr_m),
    .mat_q(mat_q)
  );

  sas_sleep_eval #(
    .NUM_DOM(NUM_DOM)
  ) u_eval (
    .clk        (clk),
    .rst        (rst),
    .mat        (mat_q),
    .can_sleep_q(cs_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_q  <= '0;
      wake_q <= '0;
    end else begin
      rsp_q  <= rsp_d;
      wake_q <= wake_d;
    end
  end

  assign rsp_valid      = rsp_q.valid;
  assign rsp_accept     = rsp_q.accept;
  assign rsp_no_session = rsp_q.no_session;
  assign can_sleep      = cs_q;
  assign wake_req       = wake_q;

endmodule

// File: rtl/sas_arbiter_checker.sv
module sas_arbiter_checker #(
  parameter int NUM_DOM = 8
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            cmd_valid,
  input logic [NUM_DOM-1:0][NUM_DOM-1:0] mat,
  input logic [NUM_DOM-1:0]              can_sleep,
  input logic                            rsp_valid,
  input logic                            rsp_accept,
  input logic                            rsp_no_session,
  input logic [NUM_DOM-1:0]              wake_req
);

  logic [NUM_DOM-1:0] diag;
  always_comb begin
    for (int i = 0; i < NUM_DOM; i++) diag[i] = mat[i][i];
  end

  // R1: outputs quiet after a reset cycle
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (can_sleep == '0 && wake_req == '0 && !rsp_valid && mat == '0));

  // R2: one response per command, none otherwise
  assert_rsp_after_cmd_R2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> rsp_valid);
  assert_no_rsp_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !rsp_valid);

  // R10: idle cycles leave the matrix alone
  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> $stable(mat));

  // R5 / R6: a rejected command changes nothing
  assert_reject_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_accept) |-> mat == $past(mat));

  // R9: the two flags never both set
  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !(rsp_accept && rsp_no_session));

  // R8: a wake pulse is single, rides an accepted response, and its target's request is clear
  assert_wake_single_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wake_req));
  assert_wake_accepted_R8: assert property (@(posedge clk) disable iff (rst)
    (wake_req != '0) |-> (rsp_valid && rsp_accept && (wake_req & diag) == '0));

endmodule

bind session_sleep_arbiter sas_arbiter_checker #(.NUM_DOM(NUM_DOM)) u_checker (
  .clk           (clk),
  .rst           (rst),
  .cmd_valid     (cmd_valid),
  .mat           (mat_q),
  .can_sleep     (can_sleep),
  .rsp_valid     (rsp_valid),
  .rsp_accept    (rsp_accept),
  .rsp_no_session(rsp_no_session),
  .wake_req      (wake_req)
);

// File: tb/session_sleep_arbiter_bench.sv
module session_sleep_arbiter_bench;

  localparam int N = 8;

  function automatic bit allowed(int s, int d);
    return (s != d) && (((3 * s + d) % 5) != 0);
  endfunction

  function automatic logic [N*N-1:0] mk_mask();
    logic [N*N-1:0] m;
    m = '0;
    for (int s = 0; s < N; s++)
      for (int d = 0; d < N; d++)
        m[s*N+d] = allowed(s, d);
    return m;
  endfunction

  localparam logic [N*N-1:0] MASK = mk_mask();

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cmd_valid = 1'b0;
  logic [1:0]   cmd_op = 2'b00;
  logic [2:0]   cmd_src = '0;
  logic [2:0]   cmd_dst = '0;
  logic         rsp_valid, rsp_accept, rsp_no_session;
  logic [N-1:0] can_sleep, wake_req;

  always #10 clk = ~clk;

  session_sleep_arbiter #(.NUM_DOM(N), .CONN_MASK(MASK)) u_session_sleep_arbiter (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_src(cmd_src), .cmd_dst(cmd_dst), .rsp_valid(rsp_valid),
    .rsp_accept(rsp_accept), .rsp_no_session(rsp_no_session),
    .can_sleep(can_sleep), .wake_req(wake_req)
  );

  int checks = 0;
  int errors = 0;
  bit model [N][N];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [N-1:0] model_cs();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) begin
      bit busy = 0;
      for (int k = 0; k < N; k++)
        if (k != i) busy = busy | model[i][k] | model[k][i];
      v[i] = model[i][i] & !busy;
    end
    return v;
  endfunction

  task automatic do_cmd(string req, logic [1:0] op, int s, int d);
    logic [N-1:0] cs_before, exp_wake;
    bit acc, nos;
    cs_before = model_cs();
    acc = 0; nos = 0; exp_wake = '0;
    case (op)
      2'b00: if (allowed(s, d)) begin
               acc = 1; model[s][d] = 1; model[d][d] = 0;
               exp_wake[d] = cs_before[d];
             end
      2'b01: if (s != d) begin
               if (model[s][d]) begin acc = 1; model[s][d] = 0; end
               else nos = 1;
             end
      2'b10: begin acc = 1; model[s][s] = 1; end
      default: begin acc = 1; model[s][s] = 0; end
    endcase
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_src = 3'(s); cmd_dst = 3'(d);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R2", "rsp_valid", 32'(rsp_valid), 32'd1);
    chk(req, "rsp_accept", 32'(rsp_accept), 32'(acc));
    chk(req, "rsp_no_session", 32'(rsp_no_session), 32'(nos));
    chk("R8", "wake_req", 32'(wake_req), 32'(exp_wake));
    @(negedge clk);
    chk("R2", "rsp_valid idle", 32'(rsp_valid), 32'd0);
    chk("R8", "wake_req after pulse", 32'(wake_req), 32'd0);
    chk("R4", "can_sleep", 32'(can_sleep), 32'(model_cs()));
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++)
      for (int k = 0; k < N; k++) model[i][k] = 0;
    repeat (3) @(negedge clk);
    chk("R1", "can_sleep in reset", 32'(can_sleep), 32'd0);
    chk("R1", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
    chk("R1", "wake_req in reset", 32'(wake_req), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "can_sleep after reset", 32'(can_sleep), 32'd0);
    chk("R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);

    // R3: every domain requests sleep
    for (int i = 0; i < N; i++) do_cmd("R3", 2'b10, i, (i + 1) % N);

    // R5 / R6 / R7 / R8: open sweep over all ordered pairs
    for (int s = 0; s < N; s++)
      for (int d = 0; d < N; d++)
        do_cmd((s == d) ? "R5" : (allowed(s, d) ? "R7" : "R6"), 2'b00, s, d);

    // R7: reopen an already open pair
    do_cmd("R7", 2'b00, 0, 1);

    // R10: garbage fields with cmd_valid low
    begin
      logic [N-1:0] cs_hold;
      cs_hold = can_sleep;
      @(negedge clk);
      cmd_op = 2'b10; cmd_src = 3'd6; cmd_dst = 3'd2;
      repeat (3) begin
        @(negedge clk);
        cmd_op = cmd_op + 2'd1;
        chk("R10", "rsp_valid while idle", 32'(rsp_valid), 32'd0);
        chk("R10", "can_sleep while idle", 32'(can_sleep), 32'(cs_hold));
      end
    end

    // R9: close sweep; open pairs accepted, others report no session
    for (int s = 0; s < N; s++)
      for (int d = 0; d < N; d++)
        do_cmd((s == d) ? "R5" : "R9", 2'b01, s, d);
    do_cmd("R9", 2'b01, 0, 1);
    do_cmd("R10", 2'b01, 6, 2);

    // R4 / R8: sleep requests with one session in each direction
    for (int i = 0; i < N; i++) do_cmd("R3", 2'b10, i, i);
    do_cmd("R8", 2'b00, 4, 5);
    do_cmd("R3", 2'b10, 5, 5);
    do_cmd("R9", 2'b01, 4, 5);
    do_cmd("R3", 2'b11, 2, 0);
    do_cmd("R8", 2'b00, 2, 3);
    do_cmd("R9", 2'b01, 2, 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule